// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt requests from five peripheral sources into an eight-bit pending register. It drives one interrupt line to a host processor while anything is pending. When the host runs an acknowledge cycle, the block picks the most urgent serviceable source by a fixed ranking. It returns that source's eight-bit vector in the next cycle.

The sources behave in two ways. The co-processor doorbell and the frame tick are one-cycle set pulses. Each stays pending until an acknowledge services it. The disk-controller request, the clock-chip request and the serial-port request are levels. Their pending bits copy the input one cycle later and an acknowledge never clears them. The clock-chip and serial-port requests raise the interrupt line but have no vector. An acknowledge that finds no serviceable source returns vector 0 and sets a sticky error flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq` is high in the cycle after any source becomes pending. It is low in the cycle after no source is pending.
- R2: On `ack`, the source serviced is the disk request if pending, otherwise the doorbell if pending, otherwise the frame tick if pending.
- R3: The vector returned is 11 (0x0B) for the disk request, 12 (0x0C) for the doorbell and 13 (0x0D) for the frame tick.
- R4: Servicing the doorbell clears only the doorbell pending bit. Servicing the frame tick clears only the frame-tick pending bit. A pulse source that is pending but not serviced stays pending.
- R5: The disk pending bit equals `disk_req` one cycle earlier. An acknowledge never clears it, so repeated acknowledges keep returning 11 while `disk_req` stays high.
- R6: `clk_req` and `uart_req` are level sources that raise `irq` while high. They are never serviced, and an acknowledge with only these pending returns vector 0.
- R7: An acknowledge with no serviceable source pending returns vector 0 and sets `ack_err`, which stays high until reset.
- R8: `vector` is registered. `vec_valid` is high for exactly the one cycle after each `ack`, and `vector` holds its value until the next `ack`.
- R9: A doorbell or frame-tick pulse that arrives in the same cycle as an acknowledge clearing that source leaves the source pending.
- R10: While and just after `rst`, `irq`, `vector`, `vec_valid` and `ack_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_req | input | 1 | Clock-chip request level (pending bit 1) |
| uart_req | input | 1 | Serial-port request level (pending bit 2) |
| db_set | input | 1 | Co-processor doorbell set pulse (pending bit 4) |
| frame_set | input | 1 | Frame tick set pulse (pending bit 5) |
| disk_req | input | 1 | Disk-controller request level (pending bit 7) |
| ack | input | 1 | Acknowledge strobe from the host |
| irq | output | 1 | Interrupt line to the host |
| vector | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | High in the cycle after an acknowledge |
| ack_err | output | 1 | Sticky flag for an acknowledge with nothing serviceable |

## Verification
The two functions that can fall in the same cycle are the set pulse of a doorbell or frame tick and the clearing of that same bit by an acknowledge that services it. The random stream asserts the pulses and `ack` independently, so this overlap occurs often. A directed case also forces it with only the doorbell pending. The outcome is judged by a second acknowledge, which must again return 12 and not report an error. The same stream also drops and raises `disk_req` between acknowledges to check that the ranking moves down and back up.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int STAT_W = 8;
    localparam int POS_W  = $clog2(STAT_W);
    localparam int VEC_W  = 8;
    localparam int NSRC   = 5;
    localparam int NRANK  = 3;

    typedef enum logic [2:0] {
        SRC_CLK   = 3'd0,
        SRC_UART  = 3'd1,
        SRC_DB    = 3'd2,
        SRC_FRAME = 3'd3,
        SRC_DISK  = 3'd4
    } src_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             level;
        logic             serv;
        logic [VEC_W-1:0] vec;
    } src_cfg_t;

    typedef struct packed {
        logic [NSRC-1:0]  grant;
        logic             none;
        logic [VEC_W-1:0] vec;
    } pick_t;

    function automatic src_cfg_t src_cfg(input int s);
        src_cfg_t c;
        case (s)
            0:       c = '{pos: POS_W'(1), level: 1'b1, serv: 1'b0, vec: VEC_W'(0)};
            1:       c = '{pos: POS_W'(2), level: 1'b1, serv: 1'b0, vec: VEC_W'(0)};
            2:       c = '{pos: POS_W'(4), level: 1'b0, serv: 1'b1, vec: VEC_W'(12)};
            3:       c = '{pos: POS_W'(5), level: 1'b0, serv: 1'b1, vec: VEC_W'(13)};
            default: c = '{pos: POS_W'(7), level: 1'b1, serv: 1'b1, vec: VEC_W'(11)};
        endcase
        return c;
    endfunction

    // rank 0 is the most urgent
    function automatic int rank_src(input int r);
        case (r)
            0:       return int'(SRC_DISK);
            1:       return int'(SRC_DB);
            default: return int'(SRC_FRAME);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] pos_of(input src_e s);
        return src_cfg(int'(s)).pos;
    endfunction

endpackage

// File: rtl/pirq_status.sv
module pirq_status
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic [NSRC-1:0]   clr,
    output logic [STAT_W-1:0] stat
);
    logic [NSRC-1:0] pend;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam src_cfg_t CFG = src_cfg(s);
        if (CFG.level) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) pend[s] <= 1'b0;
                else     pend[s] <= src_in[s];
            end
            assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
                !rst |=> pend[s] == $past(src_in[s]));
        end else begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst) pend[s] <= 1'b0;
                else     pend[s] <= src_in[s] | (pend[s] & ~clr[s]);
            end
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
                src_in[s] |=> pend[s]);
            assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
                (pend[s] && !clr[s]) |=> pend[s]);
        end
    end

    always_comb begin
        stat = '0;
        for (int s = 0; s < NSRC; s++) begin
            stat[src_cfg(s).pos] = pend[s];
        end
    end
endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import pirq_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output pick_t             pick
);
    always_comb begin
        pick       = '0;
        pick.none  = 1'b1;
        for (int r = NRANK - 1; r >= 0; r--) begin
            if (stat[src_cfg(rank_src(r)).pos]) begin
                pick.grant                = '0;
                pick.grant[rank_src(r)]   = 1'b1;
                pick.vec                  = src_cfg(rank_src(r)).vec;
                pick.none                 = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pirq_vecout.sv
module pirq_vecout
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  pick_t            pick,
    output logic [VEC_W-1:0] vector,
    output logic             vec_valid,
    output logic             ack_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vector    <= '0;
            vec_valid <= 1'b0;
            ack_err   <= 1'b0;
        end else begin
            vec_valid <= ack;
            if (ack) begin
                vector <= pick.none ? '0 : pick.vec;
                if (pick.none) ack_err <= 1'b1;
            end
        end
    end

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vec_valid && $stable(vector));
    assert_none_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && pick.none) |=> vector == '0 && ack_err);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_req,
    input  logic             uart_req,
    input  logic             db_set,
    input  logic             frame_set,
    input  logic             disk_req,
    input  logic             ack,
    output logic             irq,
    output logic [VEC_W-1:0] vector,
    output logic             vec_valid,
    output logic             ack_err
);
    logic [NSRC-1:0]   src_in;
    logic [NSRC-1:0]   clr;
    logic [STAT_W-1:0] stat;
    pick_t             pick;

    always_comb begin
        src_in                  = '0;
        src_in[SRC_CLK]         = clk_req;
        src_in[SRC_UART]        = uart_req;
        src_in[SRC_DB]          = db_set;
        src_in[SRC_FRAME]       = frame_set;
        src_in[SRC_DISK]        = disk_req;
        clr                     = ack ? pick.grant : '0;
    end

    pirq_status u_status (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .clr    (clr),
        .stat   (stat)
    );

    pirq_arbiter u_arb (
        .stat (stat),
        .pick (pick)
    );

    pirq_vecout u_vec (
        .clk       (clk),
        .rst       (rst),
        .ack       (ack),
        .pick      (pick),
        .vector    (vector),
        .vec_valid (vec_valid),
        .ack_err   (ack_err)
    );

    assign irq = |stat;

    assert_irq_level_R1: assert property (@(posedge clk) disable iff (rst)
        (clk_req || uart_req || disk_req) |=> irq);
    assert_disk_first_R2: assert property (@(posedge clk) disable iff (rst)
        (ack && stat[pos_of(SRC_DISK)]) |=> vector == VEC_W'(11) && vec_valid);
    assert_db_vec_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !stat[pos_of(SRC_DISK)] && stat[pos_of(SRC_DB)]) |=> vector == VEC_W'(12));
    assert_db_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && pick.grant[SRC_DB] && !db_set) |=> !stat[pos_of(SRC_DB)]);
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
    assert_valid_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_valid);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       clk_req, uart_req, db_set, frame_set, disk_req, ack;
    logic       irq;
    logic [7:0] vector;
    logic       vec_valid, ack_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    bit m_clk, m_uart, m_db, m_frame, m_disk, m_err, m_valid;
    logic [7:0] m_vec;

    always #4 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .clk_req(clk_req), .uart_req(uart_req),
        .db_set(db_set), .frame_set(frame_set), .disk_req(disk_req), .ack(ack),
        .irq(irq), .vector(vector), .vec_valid(vec_valid), .ack_err(ack_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ref_irq();
        return m_clk | m_uart | m_db | m_frame | m_disk;
    endfunction

    task automatic model_reset();
        m_clk = 0; m_uart = 0; m_db = 0; m_frame = 0; m_disk = 0;
        m_err = 0; m_valid = 0; m_vec = 8'd0;
    endtask

    // R2 R3 R4 R5 R9: next-state of the reference from its old state and inputs
    task automatic model_edge(input bit c, u, d, f, k, a);
        bit clr_d, clr_f;
        clr_d = 0; clr_f = 0;
        m_valid = a;
        if (a) begin
            if (m_disk)       m_vec = 8'd11;
            else if (m_db)    begin m_vec = 8'd12; clr_d = 1; end
            else if (m_frame) begin m_vec = 8'd13; clr_f = 1; end
            else              begin m_vec = 8'd0;  m_err = 1; end
        end
        m_db    = d | (m_db & ~clr_d);
        m_frame = f | (m_frame & ~clr_f);
        m_clk = c; m_uart = u; m_disk = k;
    endtask

    task automatic compare_all();
        chk("R1 irq", {7'd0, irq}, {7'd0, ref_irq()});
        chk("R3 vector", vector, m_vec);
        chk("R8 vec_valid", {7'd0, vec_valid}, {7'd0, m_valid});
        chk("R7 ack_err", {7'd0, ack_err}, {7'd0, m_err});
    endtask

    task automatic step(input bit c, u, d, f, k, a);
        clk_req = c; uart_req = u; db_set = d; frame_set = f; disk_req = k; ack = a;
        @(posedge clk);
        model_edge(c, u, d, f, k, a);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clk_req = 0; uart_req = 0; db_set = 0; frame_set = 0; disk_req = 0; ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R10 reset state
        chk("R10 irq", {7'd0, irq}, 8'd0);
        chk("R10 vector", vector, 8'd0);
        chk("R10 vec_valid", {7'd0, vec_valid}, 8'd0);
        chk("R10 ack_err", {7'd0, ack_err}, 8'd0);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        chk("R10 idle irq", {7'd0, irq}, 8'd0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        @(negedge clk);
        do_reset();

        // R2 R5: all three pending, disk wins and is not cleared
        step(0, 0, 1, 1, 1, 0);
        step(0, 0, 0, 0, 1, 1);
        chk("R5 disk vec", vector, 8'd11);
        step(0, 0, 0, 0, 1, 1);
        chk("R5 disk again", vector, 8'd11);
        // R4: disk gone, doorbell next then frame, each cleared
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R4 db vec", vector, 8'd12);
        step(0, 0, 0, 0, 0, 1);
        chk("R4 frame vec", vector, 8'd13);
        chk("R4 irq after clears", {7'd0, irq}, 8'd0);
        // R8: vector holds, valid drops
        step(0, 0, 0, 0, 0, 0);
        chk("R8 hold", vector, 8'd13);
        chk("R8 valid low", {7'd0, vec_valid}, 8'd0);
        // R9: doorbell pending, ack plus new doorbell in same cycle
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 1);
        chk("R9 first", vector, 8'd12);
        step(0, 0, 0, 0, 0, 1);
        chk("R9 still pending", vector, 8'd12);
        chk("R9 no err", {7'd0, ack_err}, 8'd0);
        // R6: only clock-chip and serial pending -> irq but vector 0
        step(1, 1, 0, 0, 0, 0);
        chk("R6 irq", {7'd0, irq}, 8'd1);
        step(1, 1, 0, 0, 0, 1);
        chk("R6 vec zero", vector, 8'd0);
        chk("R7 err set", {7'd0, ack_err}, 8'd1);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 sticky", {7'd0, ack_err}, 8'd1);
        chk("R1 irq drop", {7'd0, irq}, 8'd0);

        // constrained random with a fresh reset
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit k;
            k = (($urandom % 16) < 3) ? ~m_disk : m_disk;
            step(($urandom % 20) == 0, ($urandom % 25) == 0,
                 ($urandom % 6) == 0, ($urandom % 7) == 0, k,
                 ($urandom % 3) == 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule